// File: doc/BRIEF.md
# Overlapping On-Chip Data Window Router

This block sits between a processor's data-memory port and two places that can answer it: a small on-chip RAM and the external memory bus. Every data access carries a 16-bit address. After reset all 64 KB of that space belongs to the external bus. Software can write a two-bit window-control register. With the right code in it, a fixed window of the address space is served by the on-chip RAM instead. The on-chip RAM hides the external locations underneath it, and those accesses produce no external bus cycle.

A build parameter places the window at the top or at the bottom of the space, and a second parameter sets its size. The defaults give a 3 KB window at the top (0xF400–0xFFFF). The bottom variant is used with a 1 KB window (0x0000–0x03FF). Routing is decided in the request cycle, and the outputs are registered. A control write in the same cycle as an access therefore affects only later accesses. The RAM array and the external bus timing belong to other blocks.

Top module: `dmem_window_router`

## Requirements
- R1: After reset the window is disabled, and every access goes to the external bus. During reset and right after it, `int_sel`, `ext_req`, `int_offset`, `ext_addr`, `int_wr` and `ext_wr` are all 0.
- R2: A control write (`cfg_we`=1) stores `cfg_wdata`, where bit 0 is the fetch-map flag and bit 1 is the swap flag. The window is enabled only when the fetch-map flag is 0 and the swap flag is 1 (value 2'b10). The values 2'b00, 2'b01 and 2'b11 leave it disabled.
- R3: In the top variant (`WIN_AT_TOP`=1, `WIN_BYTES`=3072), an enabled window covers 0xF400–0xFFFF, and 0xF3FF is outside it.
- R4: In the bottom variant (`WIN_AT_TOP`=0, `WIN_BYTES`=1024), an enabled window covers 0x0000–0x03FF, and 0x0400 is outside it.
- R5: For an access routed to the window, `int_offset` equals the address minus the window base, so it runs from 0 to `WIN_BYTES`-1. It is 0 otherwise.
- R6: An access presented with `acc_valid`=1 gives exactly one of `int_sel` or `ext_req` high for one cycle, in the cycle after the request. With no request, neither is high.
- R7: A control write takes effect from the access presented in the following cycle. An access in the same cycle as the write is routed with the old setting.
- R8: An external access puts the full address on `ext_addr` and the write flag on `ext_wr`. An internal access puts the write flag on `int_wr`. Each of these is 0 when its own side is not selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Data access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Data address |
| cfg_we | input | 1 | Window-control register write strobe |
| cfg_wdata | input | 2 | bit0 fetch-map flag, bit1 swap flag |
| int_sel | output | 1 | On-chip RAM selected (one cycle per access) |
| int_wr | output | 1 | Write flag for on-chip RAM |
| int_offset | output | OFF_W | Offset inside the window |
| ext_req | output | 1 | External bus cycle request |
| ext_wr | output | 1 | Write flag for external bus |
| ext_addr | output | ADDR_W | Address for external bus |

## Verification
The bench aims at the window edges in both variants: 0xF3FF and 0xF400, 0xFFFF, 0x03FF and 0x0400. An off-by-one base or limit would send one of these to the wrong side or give a wrong offset. It walks through all four control codes, which catches a decoder that enables on a single flag. It also sends an access in the same cycle as a control write, where a design that routes on the new value would select the wrong side. Random accesses with random control writes, run on both variants, check that exactly one side answers each request and that idle cycles stay silent.

// File: rtl/dwr_pkg.sv
// Shared types and helpers for the data-window router.
// Assumes a single-cycle request interface; nothing here holds state.
package dwr_pkg;

    // Control register fields, bit 0 = fetch-map flag, bit 1 = swap flag.
    typedef struct packed {
        logic swap;
        logic fetch_map;
    } win_ctrl_t;

    // Routing decision of one access.
    typedef enum logic [1:0] {
        RT_NONE = 2'd0,
        RT_INT  = 2'd1,
        RT_EXT  = 2'd2
    } route_t;

    // Window is live only for fetch_map=0 together with swap=1.
    function automatic logic ctrl_enables(input win_ctrl_t c);
        return (!c.fetch_map) && c.swap;
    endfunction

endpackage

// File: rtl/dwr_ctrl_reg.sv
// Window-control register.
// Holds the two control flags and derives the window-enable level.
// Assumes writes are single-cycle strobes; the new value is visible
// from the cycle after the write.
module dwr_ctrl_reg
    import dwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [1:0] cfg_wdata,
    output logic       win_en
);

    win_ctrl_t ctrl_q;

    // Capture control writes; reset clears both flags (window off).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (cfg_we) begin
            ctrl_q <= win_ctrl_t'(cfg_wdata);
        end
    end

    // Decode the enable code from the stored flags.
    always_comb begin
        win_en = ctrl_enables(ctrl_q);
    end

endmodule

// File: rtl/dwr_window_match.sv
// Address comparator for the on-chip window.
// Works out whether an address falls in the window and its offset from the
// window base. AT_TOP picks the placement at the top or the bottom of the space.
// Assumes WIN_BYTES <= 2**ADDR_W and WIN_BYTES > 1.
module dwr_window_match #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned WIN_BYTES = 3072,
    parameter bit          AT_TOP    = 1'b1,
    parameter int unsigned OFF_W     = $clog2(WIN_BYTES)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [OFF_W-1:0]  offset
);

    localparam longint unsigned SPACE  = 64'd1 << ADDR_W;
    localparam longint unsigned BASE_L = AT_TOP ? (SPACE - WIN_BYTES) : 64'd0;
    localparam logic [ADDR_W-1:0] BASE = BASE_L[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(WIN_BYTES - 1);

    generate
        if (AT_TOP) begin : g_top
            // Top placement: window runs from BASE to the last address.
            always_comb begin
                hit    = (addr >= BASE);
                offset = OFF_W'(addr - BASE);
            end
        end else begin : g_bottom
            // Bottom placement: window runs from 0 to LIMIT.
            always_comb begin
                hit    = (addr <= LIMIT);
                offset = OFF_W'(addr);
            end
        end
    endgenerate

endmodule

// File: rtl/dwr_route_stage.sv
// Routing register stage.
// Sends each requested access to the on-chip side or the external side and
// registers the result, so outputs appear one cycle after the request.
// Assumes win_en reflects the control register as it was before this cycle's write.
module dwr_route_stage
    import dwr_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned OFF_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              win_en,
    input  logic              hit,
    input  logic [OFF_W-1:0]  offset,
    output logic              int_sel,
    output logic              int_wr,
    output logic [OFF_W-1:0]  int_offset,
    output logic              ext_req,
    output logic              ext_wr,
    output logic [ADDR_W-1:0] ext_addr
);

    route_t route_d;

    // Pick a side for the current request.
    always_comb begin
        if (!acc_valid) begin
            route_d = RT_NONE;
        end else if (win_en && hit) begin
            route_d = RT_INT;
        end else begin
            route_d = RT_EXT;
        end
    end

    // Register the chosen side; each side sees zeros when not chosen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_sel    <= 1'b0;
            int_wr     <= 1'b0;
            int_offset <= '0;
            ext_req    <= 1'b0;
            ext_wr     <= 1'b0;
            ext_addr   <= '0;
        end else begin
            int_sel    <= (route_d == RT_INT);
            int_wr     <= (route_d == RT_INT) && acc_write;
            int_offset <= (route_d == RT_INT) ? offset : '0;
            ext_req    <= (route_d == RT_EXT);
            ext_wr     <= (route_d == RT_EXT) && acc_write;
            ext_addr   <= (route_d == RT_EXT) ? acc_addr : '0;
        end
    end

endmodule

// File: rtl/dmem_window_router.sv
// Top of the data-window router.
// Splits data accesses between an overlapping on-chip RAM window and the
// external bus under control of a software-written two-flag register.
// Assumes one access request per cycle at most; no back-pressure.
module dmem_window_router #(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned WIN_BYTES  = 3072,
    parameter bit          WIN_AT_TOP = 1'b1,
    localparam int unsigned OFF_W     = $clog2(WIN_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_wdata,
    output logic              int_sel,
    output logic              int_wr,
    output logic [OFF_W-1:0]  int_offset,
    output logic              ext_req,
    output logic              ext_wr,
    output logic [ADDR_W-1:0] ext_addr
);

    logic             win_en;
    logic             hit;
    logic [OFF_W-1:0] offset;

    dwr_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .win_en    (win_en)
    );

    dwr_window_match #(
        .ADDR_W    (ADDR_W),
        .WIN_BYTES (WIN_BYTES),
        .AT_TOP    (WIN_AT_TOP),
        .OFF_W     (OFF_W)
    ) u_match (
        .addr   (acc_addr),
        .hit    (hit),
        .offset (offset)
    );

    dwr_route_stage #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W)
    ) u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_addr   (acc_addr),
        .win_en     (win_en),
        .hit        (hit),
        .offset     (offset),
        .int_sel    (int_sel),
        .int_wr     (int_wr),
        .int_offset (int_offset),
        .ext_req    (ext_req),
        .ext_wr     (ext_wr),
        .ext_addr   (ext_addr)
    );

endmodule

// File: rtl/dwr_checker.sv
// Property checker for the data-window router, bound to every instance.
// Assumes it sees the top's ports and its internal window-enable level.
module dwr_checker #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned WIN_BYTES = 3072,
    parameter int unsigned OFF_W     = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              win_en,
    input logic              int_sel,
    input logic              int_wr,
    input logic [OFF_W-1:0]  int_offset,
    input logic              ext_req,
    input logic              ext_wr,
    input logic [ADDR_W-1:0] ext_addr
);

    // R6: never both sides at once
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(int_sel && ext_req));

    // R6: every request is answered by one side in the next cycle
    a_r6_answered: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> (int_sel || ext_req));

    // R6: no request, no selection
    a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!int_sel && !ext_req));

    // R1/R2: with the window off every request goes external
    a_r1_off_external: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !win_en) |=> ext_req);

    // R5: offset stays inside the window
    a_r5_offset_range: assert property (@(posedge clk) disable iff (!rst_n)
        int_sel |-> (int_offset < OFF_W'(WIN_BYTES - 1) || int_offset == OFF_W'(WIN_BYTES - 1)));

    // R8: external address is the requested address
    a_r8_ext_addr: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> (!ext_req || ext_addr == $past(acc_addr)));

    // R8: write flag follows the request to its side
    a_r8_wr_flag: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> ((ext_wr || int_wr) == $past(acc_write)));

endmodule

bind dmem_window_router dwr_checker #(
    .ADDR_W    (ADDR_W),
    .WIN_BYTES (WIN_BYTES),
    .OFF_W     (OFF_W)
) u_dwr_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_addr   (acc_addr),
    .win_en     (win_en),
    .int_sel    (int_sel),
    .int_wr     (int_wr),
    .int_offset (int_offset),
    .ext_req    (ext_req),
    .ext_wr     (ext_wr),
    .ext_addr   (ext_addr)
);

// File: tb/test_dmem_window_router.sv
// Bench for the data-window router: top variant (i_dmem_window_router)
// and bottom variant (i_dmem_window_router_bot) driven with the same stimulus.
module test_dmem_window_router;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [15:0] acc_addr = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_wdata = '0;

    logic        t_int, t_iwr, t_ext, t_ewr;
    logic [11:0] t_off;
    logic [15:0] t_eaddr;
    logic        b_int, b_iwr, b_ext, b_ewr;
    logic [9:0]  b_off;
    logic [15:0] b_eaddr;

    int checks = 0;
    int failures = 0;
    bit en_model = 1'b0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmem_window_router i_dmem_window_router (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .int_sel(t_int), .int_wr(t_iwr), .int_offset(t_off),
        .ext_req(t_ext), .ext_wr(t_ewr), .ext_addr(t_eaddr)
    );

    dmem_window_router #(.WIN_BYTES(1024), .WIN_AT_TOP(1'b0)) i_dmem_window_router_bot (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .int_sel(b_int), .int_wr(b_iwr), .int_offset(b_off),
        .ext_req(b_ext), .ext_wr(b_ewr), .ext_addr(b_eaddr)
    );

    function automatic bit code_enables(input logic [1:0] code);
        return code == 2'b10;
    endfunction

    function automatic bit top_hit(input logic [15:0] a);
        return a >= 16'hF400;
    endfunction

    function automatic bit bot_hit(input logic [15:0] a);
        return a <= 16'h03FF;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_all_zero(input string req);
        check(req, "top int_sel", int'(t_int), 0);
        check(req, "top ext_req", int'(t_ext), 0);
        check(req, "top offset", int'(t_off), 0);
        check(req, "top ext_addr", int'(t_eaddr), 0);
        check(req, "bot int_sel", int'(b_int), 0);
        check(req, "bot ext_req", int'(b_ext), 0);
        check(req, "top wr", int'(t_iwr | t_ewr), 0);
        check(req, "bot wr", int'(b_iwr | b_ewr), 0);
    endtask

    // Present one access (optionally with a control write); called at a negedge.
    task automatic access(input string req, input logic [15:0] a, input logic wr,
                          input bit do_cfg, input logic [1:0] code);
        bit ti, bi;
        acc_valid = 1'b1; acc_write = wr; acc_addr = a;
        cfg_we = do_cfg; cfg_wdata = code;
        ti = en_model && top_hit(a);   // R7: routed on setting before the write
        bi = en_model && bot_hit(a);
        if (do_cfg) en_model = code_enables(code);
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0; cfg_we = 1'b0;
        check(req, "top int_sel", int'(t_int), int'(ti));
        check(req, "top ext_req", int'(t_ext), int'(!ti));
        check(req, "top offset", int'(t_off), ti ? int'(a) - 'hF400 : 0);
        check(req, "top ext_addr", int'(t_eaddr), ti ? 0 : int'(a));
        check(req, "top int_wr", int'(t_iwr), int'(ti && wr));
        check(req, "top ext_wr", int'(t_ewr), int'(!ti && wr));
        check(req, "bot int_sel", int'(b_int), int'(bi));
        check(req, "bot ext_req", int'(b_ext), int'(!bi));
        check(req, "bot offset", int'(b_off), bi ? int'(a) : 0);
        check(req, "bot ext_addr", int'(b_eaddr), bi ? 0 : int'(a));
        check(req, "bot int_wr", int'(b_iwr), int'(bi && wr));
        check(req, "bot ext_wr", int'(b_ewr), int'(!bi && wr));
    endtask

    task automatic cfg_only(input logic [1:0] code);
        cfg_we = 1'b1; cfg_wdata = code;
        en_model = code_enables(code);
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        check_all_zero("R6");   // no request: nothing selected
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all_zero("R1");   // during reset
        rst_n = 1'b1;
        @(negedge clk);
        check_all_zero("R1");   // after release

        // R1: window off after reset, edges go external
        access("R1", 16'hFFFF, 1'b0, 0, 2'b00);
        access("R1", 16'h0000, 1'b1, 0, 2'b00);
        access("R1", 16'hF400, 1'b0, 0, 2'b00);

        // R2: enable with 2'b10
        cfg_only(2'b10);
        // R3: top edges
        access("R3", 16'hF3FF, 1'b0, 0, 2'b00);
        access("R3", 16'hF400, 1'b1, 0, 2'b00);
        access("R3", 16'hFFFF, 1'b0, 0, 2'b00);
        // R4: bottom edges
        access("R4", 16'h03FF, 1'b1, 0, 2'b00);
        access("R4", 16'h0400, 1'b0, 0, 2'b00);
        access("R4", 16'h0000, 1'b0, 0, 2'b00);
        // R5: mid-window offsets
        access("R5", 16'hF800, 1'b0, 0, 2'b00);
        access("R5", 16'h0123, 1'b1, 0, 2'b00);

        // R2: the other three codes leave it disabled
        cfg_only(2'b11);
        access("R2", 16'hF400, 1'b0, 0, 2'b00);
        access("R2", 16'h0000, 1'b0, 0, 2'b00);
        cfg_only(2'b01);
        access("R2", 16'hFFFF, 1'b1, 0, 2'b00);
        access("R2", 16'h03FF, 1'b0, 0, 2'b00);
        cfg_only(2'b00);
        access("R2", 16'hF400, 1'b0, 0, 2'b00);

        // R7: same-cycle write uses old setting, next access the new
        access("R7", 16'hF400, 1'b0, 1, 2'b10);
        access("R7", 16'hF400, 1'b0, 0, 2'b00);
        access("R7", 16'h0010, 1'b1, 1, 2'b00);
        access("R7", 16'h0010, 1'b1, 0, 2'b00);

        // R6: idle cycle
        @(posedge clk);
        @(negedge clk);
        check_all_zero("R6");

        // R8 and mixed: random accesses with random control writes
        for (int i = 0; i < 600; i++) begin
            logic [15:0] a;
            int sel;
            sel = $urandom_range(0, 3);
            case (sel)
                0: a = 16'hF400 + 16'($urandom_range(0, 3071));
                1: a = 16'($urandom_range(0, 1023));
                default: a = 16'($urandom);
            endcase
            if ($urandom_range(0, 4) == 0) begin
                @(posedge clk);
                @(negedge clk);
                check_all_zero("R6");
            end
            access("R8", a, 1'($urandom), ($urandom_range(0, 7) == 0),
                   2'($urandom));
        end

        finish_run();
    end

endmodule